// File: doc/BRIEF.md
# Strobe-Timed Register Access Slave

This block lets an external processor reach an on-chip register bank over an asynchronous bus. The bus has an active-low select, an active-low data strobe, a direction line (high means read), an address and a data bus that is tri-stated. The block samples select, strobe and direction through two-flop synchronizers on its own clock. On the synchronized falling strobe it captures address and write data and issues one request towards the register bank.

The bank answers with an acknowledge. The acknowledge counts only while a separate clock-alive qualifier is high, because the bank's clock may pause. The sequencer waits a fixed number of cycles for a qualified acknowledge. If none arrives it falls back: a read returns the value kept from the most recent successful read, and a write is dropped. In either case the data bus is driven within a fixed cycle budget after the strobe falls.

After the strobe rises the block releases the bus and spends one recovery cycle before it accepts the next access.

Top module: `strobe_reg_slave`

## Requirements
- R1: After reset the output enable is 0, the returned read value is 0 and no request is raised towards the bank.
- R2: An access starts only on a synchronized falling edge of the data strobe while the synchronized select is low. A strobe falling while select is high raises no request.
- R3: Address, write data and direction are captured at access start and presented to the bank with the request (write enable is the inverse of the direction line). A write with a qualified acknowledge stores the data in the addressed register.
- R4: When the strobe falls just before a clock edge and stays low for at least 8 cycles, then by the seventh rising edge after that edge the output enable is 1 for a read, and the read data is valid.
- R5: The request is high for exactly 1 cycle when the acknowledge is qualified at once, and for at most 3 cycles when it is never qualified. After that it is low.
- R6: An acknowledge is ignored while clock-alive is low. A read that times out returns the last value captured by a successful read, which is 0 if no read has succeeded since reset.
- R7: A write that times out leaves the target register unchanged, even if the bank clock comes back after the request has dropped.
- R8: The output enable is 1 only while a read access is in its drive phase with select low. It is 0 during writes. It falls on the third rising edge after the strobe rises.
- R9: After the drive phase there is one recovery cycle. A strobe edge that falls during the recovery cycle does not start an access, and the next proper falling strobe does start one.
- R10: The held read value changes only when a read completes with a qualified acknowledge. Writes and timed-out reads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the slowest-clock cycle unit |
| rstN | input | 1 | Active-low synchronous reset |
| busCsN | input | 1 | Asynchronous active-low select |
| busDsN | input | 1 | Asynchronous active-low data strobe |
| busRw | input | 1 | Direction, 1 = read, 0 = write |
| busAddr | input | ADDR_W | Register address |
| busWrData | input | DATA_W | Write data from the processor |
| busRdData | output | DATA_W | Read data towards the pad |
| busOe | output | 1 | Pad output enable, 1 drives the data bus |
| tgtReq | output | 1 | Request to the register bank |
| tgtWe | output | 1 | Write enable qualifying the request |
| tgtAddr | output | ADDR_W | Captured address |
| tgtWrData | output | DATA_W | Captured write data |
| tgtRdData | input | DATA_W | Read data from the bank |
| tgtAck | input | 1 | Bank acknowledge |
| tgtClkAlive | input | 1 | High while the bank clock is running |

## Verification
The bench changes every input on a falling clock edge and samples on falling edges. A strobe that falls on a falling edge is first seen at the next rising edge. From there the expected cycles are: 2 edges of synchronization, 1 edge to detect the fall, 1 edge to capture, and then 1 to 3 cycles of request. So data and enable are checked exactly 7 falling edges after the strobe falls. The release of the bus is checked 2 and 3 falling edges after the strobe rises, so both the latest cycle the bus may still be driven and the first cycle it must be released are pinned down. Request length is counted on rising edges and compared with 1 or 3 for each access. Register contents after a dropped write are read back through the bus.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPTURE,
    ST_WAIT,
    ST_DRIVE,
    ST_RECOVER
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic loadRead;
  } ctrlStrb_t;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) stage[g] <= RST_VAL;
          else       stage[g] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) stage[g] <= RST_VAL;
          else       stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int WAIT_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csS,
  input  logic      dsS,
  input  logic      rwS,
  input  logic      tgtAck,
  input  logic      tgtClkAlive,
  output ctrlStrb_t strb,
  output logic      tgtReq,
  output logic      tgtWe,
  output logic      busOe
);
  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  seqState_t state, stateNxt;
  logic [CW-1:0] waitCnt;
  logic dsPrev, isRead, ackQ, startAcc, dsFall;

  assign dsFall   = dsPrev & ~dsS;
  assign startAcc = (state == ST_IDLE) & dsFall & ~csS;
  assign ackQ     = tgtAck & tgtClkAlive;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:     if (startAcc) stateNxt = ST_CAPTURE;
      ST_CAPTURE:  stateNxt = ST_WAIT;
      ST_WAIT:     if (ackQ || waitCnt == LAST) stateNxt = ST_DRIVE;
      ST_DRIVE:    if (dsS) stateNxt = ST_RECOVER;
      ST_RECOVER:  stateNxt = ST_IDLE;
      default:     stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dsPrev  <= 1'b1;
      isRead  <= 1'b1;
      waitCnt <= '0;
    end else begin
      state  <= stateNxt;
      dsPrev <= dsS;
      if (startAcc) isRead <= rwS;
      if (state == ST_WAIT) waitCnt <= waitCnt + 1'b1;
      else                  waitCnt <= '0;
    end
  end

  assign tgtReq        = (state == ST_WAIT);
  assign tgtWe         = ~isRead;
  assign strb.capture  = startAcc;
  assign strb.loadRead = (state == ST_WAIT) & ackQ & isRead;
  assign busOe         = (state == ST_DRIVE) & isRead & ~csS;

  // run length of the request, used by the checks below
  logic [CW:0] reqRun;
  always_ff @(posedge clk) begin
    if (!rstN)       reqRun <= '0;
    else if (tgtReq) reqRun <= reqRun + 1'b1;
    else             reqRun <= '0;
  end

  // R5
  req_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqRun <= (CW+1)'(WAIT_CYCLES));

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtReq && ackQ) |=> !tgtReq);

  // R9
  recover_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER) |=> (state == ST_IDLE) && !tgtReq);

  // R8
  oe_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && dsS) |=> !busOe);

  // R2
  start_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && csS) |=> (state == ST_IDLE));
endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] tgtRdData,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [DATA_W-1:0] tgtWrData,
  output logic [DATA_W-1:0] busRdData
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] lastRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      wrDataQ  <= '0;
      lastRead <= '0;
    end else begin
      if (strb.capture) begin
        addrQ   <= busAddr;
        wrDataQ <= busWrData;
      end
      if (strb.loadRead) lastRead <= tgtRdData;
    end
  end

  assign tgtAddr   = addrQ;
  assign tgtWrData = wrDataQ;
  assign busRdData = lastRead;

  // R10
  held_read_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadRead |=> $stable(busRdData));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(tgtAddr) && $stable(tgtWrData));
endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave
  import srs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCsN,
  input  logic              busDsN,
  input  logic              busRw,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              busOe,
  output logic              tgtReq,
  output logic              tgtWe,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [DATA_W-1:0] tgtWrData,
  input  logic [DATA_W-1:0] tgtRdData,
  input  logic              tgtAck,
  input  logic              tgtClkAlive
);
  logic [2:0] ctlSync;
  ctrlStrb_t  strb;

  srs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  ({busCsN, busDsN, busRw}),
    .dout (ctlSync)
  );

  srs_ctrl #(.WAIT_CYCLES(WAIT_CYCLES)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .csS         (ctlSync[2]),
    .dsS         (ctlSync[1]),
    .rwS         (ctlSync[0]),
    .tgtAck      (tgtAck),
    .tgtClkAlive (tgtClkAlive),
    .strb        (strb),
    .tgtReq      (tgtReq),
    .tgtWe       (tgtWe),
    .busOe       (busOe)
  );

  srs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .tgtRdData (tgtRdData),
    .tgtAddr   (tgtAddr),
    .tgtWrData (tgtWrData),
    .busRdData (busRdData)
  );
endmodule

// File: tb/strobe_reg_slave_tb.sv
module strobe_reg_slave_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busCsN = 1'b1, busDsN = 1'b1, busRw = 1'b1;
  logic [7:0] busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData, tgtWrData, tgtRdData;
  logic [7:0] tgtAddr;
  logic busOe, tgtReq, tgtWe, tgtAck;
  logic alive = 1'b1;

  int compared = 0, mismatched = 0, reqCount = 0;
  bit done = 0;

  always #2 clk = ~clk;

  strobe_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .busCsN(busCsN), .busDsN(busDsN), .busRw(busRw),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .busOe(busOe),
    .tgtReq(tgtReq), .tgtWe(tgtWe), .tgtAddr(tgtAddr), .tgtWrData(tgtWrData),
    .tgtRdData(tgtRdData), .tgtAck(tgtAck), .tgtClkAlive(alive)
  );

  // bank model: acknowledges at once; its clock runs only while alive
  logic [15:0] bank [256];
  assign tgtAck    = tgtReq;
  assign tgtRdData = bank[tgtAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) bank[i] <= '0;
    end else if (tgtReq && tgtWe && tgtAck && alive) begin
      bank[tgtAddr] <= tgtWrData;
    end
    if (rstN && tgtReq) reqCount <= reqCount + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // strobe falls on a negedge; sample 7 negedges later, release after 8
  task automatic access(input logic rd, input logic [7:0] a, input logic [15:0] wd,
                        input logic live, input logic [15:0] expRd);
    int reqStart;
    @(negedge clk);
    alive = live; busCsN = 1'b0; busRw = rd; busAddr = a; busWrData = wd;
    reqStart = reqCount;
    @(negedge clk);
    busDsN = 1'b0;
    repeat (7) @(negedge clk);
    if (rd) begin
      chk(live ? "R4 read enable" : "R6 stalled enable", 32'(busOe), 32'd1);
      chk(live ? "R4 read data" : "R6 stalled read data", 32'(busRdData), 32'(expRd));
    end else begin
      chk("R8 no enable on write", 32'(busOe), 32'd0);
    end
    chk("R5 request length", 32'(reqCount - reqStart), live ? 32'd1 : 32'd3);
    @(negedge clk);
    busDsN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 still driving", 32'(busOe), 32'(rd));
    @(negedge clk);
    chk("R8 released", 32'(busOe), 32'd0);
    busCsN = 1'b1;
    repeat (3) @(negedge clk);
    alive = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // {read, addr, wdata, alive, expected read}
  localparam logic [41:0] VEC [8] = '{
    {1'b0, 8'h11, 16'h1234, 1'b1, 16'h0000},  // R3 write
    {1'b1, 8'h11, 16'h0000, 1'b1, 16'h1234},  // R3 R4 read back
    {1'b0, 8'h22, 16'hBEEF, 1'b1, 16'h0000},  // R3 write
    {1'b0, 8'h11, 16'h5555, 1'b0, 16'h0000},  // R7 stalled write
    {1'b1, 8'h11, 16'h0000, 1'b1, 16'h1234},  // R7 old value kept
    {1'b1, 8'h22, 16'h0000, 1'b0, 16'h1234},  // R6 R10 last read
    {1'b1, 8'h22, 16'h0000, 1'b1, 16'hBEEF},  // R4 read
    {1'b1, 8'h11, 16'h0000, 1'b0, 16'hBEEF}   // R6 stalled read
  };

  initial begin
    int base;
    repeat (4) @(negedge clk);
    chk("R1 enable at reset", 32'(busOe), 32'd0);
    chk("R1 read value at reset", 32'(busRdData), 32'd0);
    chk("R1 request at reset", 32'(tgtReq), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R6 R10: stalled read straight after reset gives the cleared value
    access(1'b1, 8'h05, 16'h0, 1'b0, 16'h0000);

    for (int i = 0; i < 8; i++) begin
      access(VEC[i][41], VEC[i][40:33], VEC[i][32:17], VEC[i][16], VEC[i][15:0]);
    end

    // R2: strobe with select high
    base = reqCount;
    busRw = 1'b1;
    @(negedge clk) busDsN = 1'b0;
    repeat (12) @(negedge clk);
    chk("R2 no request without select", 32'(reqCount - base), 32'd0);
    chk("R2 no enable without select", 32'(busOe), 32'd0);
    busDsN = 1'b1;
    repeat (4) @(negedge clk);

    // R9: strobe high for one cycle only, fall lands in recovery
    busCsN = 1'b0; busRw = 1'b1; busAddr = 8'h22;
    @(negedge clk) busDsN = 1'b0;
    repeat (8) @(negedge clk);
    busDsN = 1'b1;
    @(negedge clk) busDsN = 1'b0;
    base = reqCount;
    repeat (12) @(negedge clk);
    chk("R9 no access from recovery", 32'(reqCount - base), 32'd0);
    chk("R9 bus released", 32'(busOe), 32'd0);
    busDsN = 1'b1; busCsN = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b1, 8'h22, 16'h0, 1'b1, 16'hBEEF);  // R9 next access works

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule